// File: doc/BRIEF.md
# Nametable Mirroring and Bank Routing Unit

This block serves the picture processor's nametable window (0x2000 up to the palette area at 0x3F00). For every fetch it chooses which of four 8-bit bank slots backs the addressed 1 KB quadrant. It decides whether the data comes from the external character ROM or from the console's internal nametable RAM. It also produces the single A10 line that both memories share.

A six-bit style byte controls the block. Its low three bits choose how quadrants are grouped onto slots. Bit 4 chooses the data source. Bit 5 lets bits 3–2 replace the bank's lowest bit with a fixed mirroring rule: follow address bit 10, follow address bit 11, tie low or tie high. The rule that applies depends on the mode in bits 1–0. This gives vertical, horizontal, one-screen, four-screen and 2 KB-spread layouts.

The unit is purely combinational. Every output follows its inputs within the same cycle, and there is no internal state.

Top module: `nt_mirror_unit`

## Requirements
- R1: Slot choice per quadrant q = ppu_addr[11:10]. For style[2:0] of 1 or 5, the unit uses slot q. For 2, 3 or 4 it uses slot 2+ppu_addr[10]. For 0, 6 or 7 it uses slot 2+ppu_addr[11]. Slot k is bank_slots[k].
- R2: chr_hi[7:1] always equals bits 7:1 of the chosen slot.
- R3: With style[5]=0, chr_hi[0] is bit 0 of the chosen slot for every other style value.
- R4: With style[5]=1 and style[1:0]=0, chr_hi[0] depends on style[3:2]. The value 0 gives ppu_addr[10], 1 gives ppu_addr[11], 2 gives 0 and 3 gives 1.
- R5: With style[5]=1 and style[1:0]=3, chr_hi[0] depends on style[3:2]. The value 0 gives ppu_addr[11], 1 gives ppu_addr[10], 2 gives 1 and 3 gives 0.
- R6: With style[5]=1 and style[1:0] of 1 or 2, chr_hi[0] is bit 0 of the chosen slot.
- R7: ciram_a10 always equals chr_hi[0].
- R8: Inside the window 0x2000–0x3EFF, rom_sel=1 and ciram_sel=0 when style[4]=1. When style[4]=0, ciram_sel=1 and rom_sel=0.
- R9: For any address with ppu_addr[13]=0, or at or above 0x3F00, both rom_sel and ciram_sel are 0, whatever the style.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ppu_addr | input | 14 | Picture processor address A13–A0 |
| style | input | 6 | Banking style byte, bits 5–0 |
| bank_slots | input | 4x8 | Bank slots 0..3, slot k at bank_slots[k] |
| chr_hi | output | 8 | Character ROM address bits A17–A10 |
| ciram_a10 | output | 1 | A10 to the internal nametable RAM |
| rom_sel | output | 1 | Nametable read goes to character ROM |
| ciram_sel | output | 1 | Nametable read goes to internal RAM |

## Verification
The assertions check several properties on every evaluation:
- The two source selects are never both active.
- Both selects are idle outside the nametable window.
- The four-screen grouping and the no-override modes pass the chosen slot through untouched.

Only the bench's sweep can show the rest. That covers the exact override mapping for each of the sixteen mirroring settings in modes 0 and 3, the slot grouping for the other modes, and the window edges at 0x1FFF, 0x3EFF and 0x3F00. The sweep crosses all 64 style values with every quadrant, two mirror regions and slots of both parities.

// File: rtl/nt_mirror_pkg.sv
package nt_mirror_pkg;
   localparam int unsigned NUM_SLOTS = 4;
   localparam int unsigned STYLE_W   = 6;

   typedef enum logic [2:0] {
      A10_FROM_SLOT = 3'd0,
      A10_FROM_PA10 = 3'd1,
      A10_FROM_PA11 = 3'd2,
      A10_TIE_LOW   = 3'd3,
      A10_TIE_HIGH  = 3'd4
   } a10_src_e;

   typedef enum logic [1:0] {
      GRP_PAIR_HI   = 2'd0,
      GRP_FOUR      = 2'd1,
      GRP_ALTERNATE = 2'd2
   } slot_group_e;
endpackage

// File: rtl/nt_slot_pick.sv
module nt_slot_pick
   import nt_mirror_pkg::*;
#(
   parameter int unsigned BANK_W = 8
) (
   input  logic [2:0]                         grp_code,
   input  logic [1:0]                         quad,
   input  logic [NUM_SLOTS-1:0][BANK_W-1:0]   slots,
   output logic [BANK_W-1:0]                  bank
);
   slot_group_e grp;
   logic [NUM_SLOTS-1:0][BANK_W-1:0] cand;

   always_comb begin
      unique case (grp_code)
         3'd1, 3'd5:       grp = GRP_FOUR;
         3'd2, 3'd3, 3'd4: grp = GRP_ALTERNATE;
         default:          grp = GRP_PAIR_HI;
      endcase
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_quad
      localparam logic [1:0] QG = 2'(g);
      always_comb begin
         unique case (grp)
            GRP_FOUR:      cand[g] = slots[QG];
            GRP_ALTERNATE: cand[g] = slots[{1'b1, QG[0]}];
            default:       cand[g] = slots[{1'b1, QG[1]}];
         endcase
      end
   end

   assign bank = cand[quad];
endmodule

// File: rtl/nt_a10_override.sv
module nt_a10_override
   import nt_mirror_pkg::*;
(
   input  logic [STYLE_W-1:0] style,
   input  logic               pa10,
   input  logic               pa11,
   input  logic               slot_lsb,
   output logic               a10,
   output a10_src_e           src
);
   always_comb begin
      src = A10_FROM_SLOT;
      if (style[5]) begin
         unique case (style[1:0])
            2'd0: begin
               unique case (style[3:2])
                  2'd0: src = A10_FROM_PA10;
                  2'd1: src = A10_FROM_PA11;
                  2'd2: src = A10_TIE_LOW;
                  default: src = A10_TIE_HIGH;
               endcase
            end
            2'd3: begin
               unique case (style[3:2])
                  2'd0: src = A10_FROM_PA11;
                  2'd1: src = A10_FROM_PA10;
                  2'd2: src = A10_TIE_HIGH;
                  default: src = A10_TIE_LOW;
               endcase
            end
            default: src = A10_FROM_SLOT;
         endcase
      end
   end

   always_comb begin
      unique case (src)
         A10_FROM_PA10: a10 = pa10;
         A10_FROM_PA11: a10 = pa11;
         A10_TIE_LOW:   a10 = 1'b0;
         A10_TIE_HIGH:  a10 = 1'b1;
         default:       a10 = slot_lsb;
      endcase
   end
endmodule

// File: rtl/nt_window_route.sv
module nt_window_route #(
   parameter int unsigned AW       = 14,
   parameter int unsigned PAL_BASE = 14'h3F00
) (
   input  logic [AW-1:0] addr,
   input  logic          rom_mode,
   output logic          rom_sel,
   output logic          ciram_sel
);
   localparam logic [AW-1:0] PAL_LIM = AW'(PAL_BASE);
   logic in_win;

   assign in_win    = addr[AW-1] && (addr < PAL_LIM);
   assign rom_sel   = in_win &&  rom_mode;
   assign ciram_sel = in_win && !rom_mode;

   always_comb begin
      a_r8_one_source: assert (!(rom_sel && ciram_sel))
         else $error("both nametable sources selected");
   end
endmodule

// File: rtl/nt_mirror_unit.sv
module nt_mirror_unit
   import nt_mirror_pkg::*;
#(
   parameter int unsigned BANK_W   = 8,
   parameter int unsigned OFFS_W   = 10,
   parameter int unsigned PPU_AW   = 14,
   parameter int unsigned PAL_BASE = 14'h3F00
) (
   input  logic [PPU_AW-1:0]                  ppu_addr,
   input  logic [STYLE_W-1:0]                 style,
   input  logic [NUM_SLOTS-1:0][BANK_W-1:0]   bank_slots,
   output logic [BANK_W-1:0]                  chr_hi,
   output logic                               ciram_a10,
   output logic                               rom_sel,
   output logic                               ciram_sel
);
   localparam int unsigned QUAD_LO = OFFS_W;
   localparam int unsigned QUAD_HI = OFFS_W + 1;

   if (BANK_W < 2) begin : g_bad_bank
      $error("BANK_W must be at least 2");
   end
   if (PPU_AW < OFFS_W + 4) begin : g_bad_aw
      $error("PPU_AW too narrow for quadrant and window decode");
   end

   logic [1:0]        quad;
   logic [BANK_W-1:0] pick_bank;
   logic              a10;
   a10_src_e          a10_src;

   assign quad = ppu_addr[QUAD_HI:QUAD_LO];

   nt_slot_pick #(.BANK_W(BANK_W)) u_pick (
      .grp_code (style[2:0]),
      .quad     (quad),
      .slots    (bank_slots),
      .bank     (pick_bank)
   );

   nt_a10_override u_ovr (
      .style    (style),
      .pa10     (ppu_addr[QUAD_LO]),
      .pa11     (ppu_addr[QUAD_HI]),
      .slot_lsb (pick_bank[0]),
      .a10      (a10),
      .src      (a10_src)
   );

   nt_window_route #(.AW(PPU_AW), .PAL_BASE(PAL_BASE)) u_route (
      .addr      (ppu_addr),
      .rom_mode  (style[4]),
      .rom_sel   (rom_sel),
      .ciram_sel (ciram_sel)
   );

   assign chr_hi    = {pick_bank[BANK_W-1:1], a10};
   assign ciram_a10 = a10;

   always_comb begin
      a_r9_idle_outside: assert (ppu_addr[PPU_AW-1] || (!rom_sel && !ciram_sel))
         else $error("source select active outside window");
      if (style[2:0] == 3'd1 || style[2:0] == 3'd5) begin
         a_r1_four_screen: assert (chr_hi[BANK_W-1:1] == bank_slots[quad][BANK_W-1:1])
            else $error("four-screen grouping used wrong slot");
      end
      if (!style[5]) begin
         a_r3_lsb_passthru: assert (chr_hi == pick_bank && a10_src == A10_FROM_SLOT)
            else $error("override applied with bit 5 clear");
      end
      if (style[5] && (style[1:0] == 2'd1 || style[1:0] == 2'd2)) begin
         a_r6_no_override: assert (chr_hi == pick_bank)
            else $error("override applied in modes 1/2");
      end
   end
endmodule

// File: tb/sim_nt_mirror_unit.sv
module sim_nt_mirror_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [13:0]     addr;
   logic [5:0]      sty;
   logic [3:0][7:0] slots;
   logic [7:0]      chr_hi;
   logic            ciram_a10, rom_sel, ciram_sel;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   nt_mirror_unit u0 (
      .ppu_addr  (addr),
      .style     (sty),
      .bank_slots(slots),
      .chr_hi    (chr_hi),
      .ciram_a10 (ciram_a10),
      .rom_sel   (rom_sel),
      .ciram_sel (ciram_sel)
   );

   task automatic check_eq(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: sty=%02h addr=%04h act=%0h exp=%0h", tag, sty, addr, act, exp);
      end
   endtask

   function automatic int slot_of(int m, int q);
      if (m == 1 || m == 5) return q;
      if (m >= 2 && m <= 4) return 2 + (q % 2);
      return 2 + q / 2;
   endfunction

   function automatic int exp_lsb(int s, int a10b, int a11b, int reglsb);
      int ov;
      int lo;
      if (((s >> 5) & 1) == 0) return reglsb;
      lo = s % 4;
      ov = (s >> 2) % 4;
      if (lo == 0) begin
         if (ov == 0) return a10b;
         if (ov == 1) return a11b;
         return ov - 2;
      end
      if (lo == 3) begin
         if (ov == 0) return a11b;
         if (ov == 1) return a10b;
         return 3 - ov;
      end
      return reglsb;
   endfunction

   function automatic string lsb_tag(int s);
      if (((s >> 5) & 1) == 0) return "R3";
      if (s % 4 == 0) return "R4";
      if (s % 4 == 3) return "R5";
      return "R6";
   endfunction

   task automatic apply(int a, int s);
      @(negedge clk);
      addr = 14'(a);
      sty  = 6'(s);
      #2;
   endtask

   task automatic check_all();
      int a  = int'(addr);
      int s  = int'(sty);
      int q  = (a >> 10) % 4;
      int k  = slot_of(s % 8, q);
      int el = exp_lsb(s, q % 2, q / 2, int'(slots[k][0]));
      bit inw = (a >= 'h2000) && (a < 'h3F00);
      check_eq("R1/R2 upper bank", int'(chr_hi[7:1]), int'(slots[k][7:1]));
      check_eq(lsb_tag(s), int'(chr_hi[0]), el);
      check_eq("R7 ciram a10", int'(ciram_a10), int'(chr_hi[0]));
      check_eq(inw ? "R8 rom_sel" : "R9 rom_sel", int'(rom_sel), (inw && sty[4]) ? 1 : 0);
      check_eq(inw ? "R8 ciram_sel" : "R9 ciram_sel", int'(ciram_sel), (inw && !sty[4]) ? 1 : 0);
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      addr  = 14'h0000;
      sty   = 6'h00;
      slots = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      #2;
      // idle state with all-zero inputs: R9
      check_eq("R9 idle rom", int'(rom_sel), 0);
      check_eq("R9 idle ciram", int'(ciram_sel), 0);

      // exhaustive sweep over all 64 style values (R1..R9)
      for (int ps = 0; ps < 2; ps++) begin
         for (int k = 0; k < 4; k++)
            slots[k] = (8'h40 + 8'(k) * 8'h12) ^ (ps != 0 ? 8'h81 : 8'h00);
         for (int s = 0; s < 64; s++)
            for (int q = 0; q < 4; q++)
               for (int r = 0; r < 2; r++) begin
                  apply('h2000 + r * 'h1000 + q * 'h400 + (r != 0 ? 'h2AA : 'h155), s);
                  check_all();
               end
      end

      // window edges for R8 and R9, both source settings
      for (int s = 0; s < 2; s++) begin
         apply('h3EFF, s * 'h10 + 'h20); check_all();
         apply('h3F00, s * 'h10 + 'h20); check_all();
         apply('h3FFF, s * 'h10);        check_all();
         apply('h1FFF, s * 'h10);        check_all();
         apply('h0400, s * 'h10 + 'h21); check_all();
         apply('h2000, s * 'h10 + 'h2C); check_all();
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule